// File: doc/BRIEF.md
# Per-Lane Data Gating and Control

This block sits beside the serial data path of a twelve-lane parallel optical link. It holds a small set of per-lane control fields and applies them to each lane's data bit on the way through. The fields are polarity inversion, lane deactivation, a squelch override and a margin-mode flag. Each lane's bit is then passed, inverted, or forced quiet. Quiet is forced by a lane fault, by deactivation, or by loss of signal.

Control fields are written one field at a time. A single strobe carries a twelve-bit vector, one bit per lane, together with a two-bit field selector. A separate synchronous control-reset input puts every field back to its power-on value without touching the rest of the chip. The gating path from data, loss-of-signal and fault to the outputs is combinational. Only the control fields are stored, so a data or fault change shows at the outputs in the same cycle.

Top module: `lane_ctl_top`

## Requirements
- R1: Each of the twelve lanes has its own control bits. Changing one lane's bit in a field write leaves every other lane's output unchanged.
- R2: When a lane is passing data, its output equals its input data bit XOR that lane's invert bit, and its enable output is 1.
- R3: A lane whose deactivate bit is 1 drives output 0 and enable 0.
- R4: A lane with loss of signal asserted and its squelch-disable bit at 0 drives output 0 and enable 0.
- R5: A lane whose squelch-disable bit is 1 ignores its loss-of-signal input. Its output and enable then depend only on the fault and deactivate conditions.
- R6: A lane with its fault input asserted drives output 0 and enable 0, whatever its control bits hold. The order of precedence, highest first, is fault, then deactivate, then loss-of-signal squelch, then normal data.
- R7: A quiet lane drives a constant 0 even when its invert bit is 1, because inversion is applied before the quiet override.
- R8: Each lane's margin output equals that lane's stored margin-mode bit.
- R9: A cycle with `cfg_rst` high returns all fields to their defaults from the next clock edge. The defaults are no inversion, no deactivation, squelch active (squelch-disable 0) and margin off.
- R10: A field write with `cfg_wr` high takes effect at the clock edge where the strobe is sampled. Outputs before that edge still use the old settings. The `cfg_field` encodings are 0 invert, 1 deactivate, 2 squelch-disable and 3 margin.
- R11: After `rst`, every field holds its default and every lane passes its data unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rst | input | 1 | Synchronous control-field reset to defaults |
| cfg_wr | input | 1 | Field write strobe |
| cfg_field | input | 2 | Field selector (0 invert, 1 deactivate, 2 squelch-disable, 3 margin) |
| cfg_wdata | input | 12 | New field value, one bit per lane |
| din | input | 12 | Per-lane input data bits |
| los | input | 12 | Per-lane loss-of-signal indication |
| fault | input | 12 | Per-lane fault indication |
| dout | output | 12 | Per-lane gated data bits |
| lane_en | output | 12 | Per-lane enable (1 when the lane passes data) |
| margin_o | output | 12 | Per-lane margin-mode indication |

## Verification
The gating function is driven with random data, loss-of-signal, fault and field contents. Random patterns make every lane land in every mix of causes at once, and this separates the precedence order from any single-cause behaviour. Directed patterns then isolate each feature:
- all-ones inversion with every lane quiet tells the inversion stage apart from the quiet override;
- a single-lane deactivate exposes any cross-lane leakage;
- a write sampled in the same step as its check pins down the cycle in which a setting takes effect;
- a control reset after dense random settings confirms that every field returns to its default.

// File: rtl/lane_ctl_pkg.sv
package lane_ctl_pkg;

    localparam int unsigned LANES_DEFAULT = 12;

    typedef enum logic [1:0] {
        FLD_INVERT = 2'd0,
        FLD_DEACT  = 2'd1,
        FLD_SQDIS  = 2'd2,
        FLD_MARGIN = 2'd3
    } field_sel_e;

    typedef enum logic [1:0] {
        GATE_PASS    = 2'd0,
        GATE_SQUELCH = 2'd1,
        GATE_DEACT   = 2'd2,
        GATE_FAULT   = 2'd3
    } gate_cause_e;

    typedef struct packed {
        logic invert;
        logic deact;
        logic sq_dis;
        logic margin;
    } lane_cfg_t;

    localparam lane_cfg_t CFG_DEFAULT = '{invert: 1'b0, deact: 1'b0, sq_dis: 1'b0, margin: 1'b0};

    // Precedence: fault, deactivate, LOS squelch, pass.
    function automatic gate_cause_e pick_cause(lane_cfg_t c, logic los, logic flt);
        if (flt)                   return GATE_FAULT;
        else if (c.deact)          return GATE_DEACT;
        else if (los && !c.sq_dis) return GATE_SQUELCH;
        else                       return GATE_PASS;
    endfunction

endpackage

// File: rtl/lane_cfg_regs.sv
module lane_cfg_regs
    import lane_ctl_pkg::*;
#(
    parameter int unsigned N = LANES_DEFAULT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_rst,
    input  logic                  wr_en,
    input  field_sel_e            wr_field,
    input  logic [N-1:0]          wr_data,
    output lane_cfg_t [N-1:0]     cfg_q
);

    logic [N-1:0] inv_vec;
    logic [N-1:0] margin_vec;

    for (genvar i = 0; i < N; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || cfg_rst) begin
                cfg_q[i] <= CFG_DEFAULT;
            end else if (wr_en) begin
                case (wr_field)
                    FLD_INVERT: cfg_q[i].invert <= wr_data[i];
                    FLD_DEACT:  cfg_q[i].deact  <= wr_data[i];
                    FLD_SQDIS:  cfg_q[i].sq_dis <= wr_data[i];
                    FLD_MARGIN: cfg_q[i].margin <= wr_data[i];
                    default:    cfg_q[i]        <= cfg_q[i];
                endcase
            end
        end
        assign inv_vec[i]    = cfg_q[i].invert;
        assign margin_vec[i] = cfg_q[i].margin;
    end

    // R9: a control reset leaves every field at its default.
    assert_cfg_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_rst) |-> (cfg_q == '0));

    // R10: a sampled invert write lands at that edge.
    assert_inv_write_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(cfg_rst) && !$past(rst) && $past(wr_field) == FLD_INVERT)
        |-> (inv_vec == $past(wr_data)));

    // R10: a margin write lands at that edge.
    assert_margin_write_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(cfg_rst) && !$past(rst) && $past(wr_field) == FLD_MARGIN)
        |-> (margin_vec == $past(wr_data)));

endmodule

// File: rtl/lane_gate.sv
module lane_gate
    import lane_ctl_pkg::*;
(
    input  lane_cfg_t cfg,
    input  logic      din,
    input  logic      los,
    input  logic      flt,
    output logic      dout,
    output logic      en,
    output logic      margin
);

    gate_cause_e cause;
    logic        pol_bit;

    always_comb begin
        cause   = pick_cause(cfg, los, flt);
        pol_bit = din ^ cfg.invert;
        en      = (cause == GATE_PASS);
        dout    = en ? pol_bit : 1'b0;
        margin  = cfg.margin;
    end

endmodule

// File: rtl/lane_ctl_top.sv
module lane_ctl_top
    import lane_ctl_pkg::*;
#(
    parameter int unsigned N = LANES_DEFAULT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_rst,
    input  logic         cfg_wr,
    input  logic [1:0]   cfg_field,
    input  logic [N-1:0] cfg_wdata,
    input  logic [N-1:0] din,
    input  logic [N-1:0] los,
    input  logic [N-1:0] fault,
    output logic [N-1:0] dout,
    output logic [N-1:0] lane_en,
    output logic [N-1:0] margin_o
);

    lane_cfg_t [N-1:0] cfg_q;

    lane_cfg_regs #(.N(N)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cfg_rst  (cfg_rst),
        .wr_en    (cfg_wr),
        .wr_field (field_sel_e'(cfg_field)),
        .wr_data  (cfg_wdata),
        .cfg_q    (cfg_q)
    );

    for (genvar i = 0; i < N; i++) begin : g_gate
        lane_gate u_gate (
            .cfg    (cfg_q[i]),
            .din    (din[i]),
            .los    (los[i]),
            .flt    (fault[i]),
            .dout   (dout[i]),
            .en     (lane_en[i]),
            .margin (margin_o[i])
        );

        // R6: a faulted lane never reports enabled.
        assert_fault_off_R6: assert property (@(posedge clk) disable iff (rst)
            fault[i] |-> !lane_en[i]);

        // R7: a quiet lane is held at 0.
        assert_quiet_zero_R7: assert property (@(posedge clk) disable iff (rst)
            !lane_en[i] |-> (dout[i] == 1'b0));

        // R8: margin only moves after a margin write or a control reset.
        assert_margin_hold_R8: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$stable(margin_o[i])) |->
            ($past(cfg_rst) || ($past(cfg_wr) && $past(cfg_field) == 2'd3)));
    end

endmodule

// File: tb/sim_lane_ctl_top.sv
`timescale 1ns/1ps
module sim_lane_ctl_top;

    localparam int N = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_rst = 1'b0;
    logic         cfg_wr = 1'b0;
    logic [1:0]   cfg_field = '0;
    logic [N-1:0] cfg_wdata = '0;
    logic [N-1:0] din = '0;
    logic [N-1:0] los = '0;
    logic [N-1:0] fault = '0;
    logic [N-1:0] dout;
    logic [N-1:0] lane_en;
    logic [N-1:0] margin_o;

    logic [N-1:0] m_inv = '0, m_deact = '0, m_sqdis = '0, m_margin = '0;
    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lane_ctl_top #(.N(N)) u0 (
        .clk(clk), .rst(rst), .cfg_rst(cfg_rst), .cfg_wr(cfg_wr),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .din(din),
        .los(los), .fault(fault), .dout(dout), .lane_en(lane_en),
        .margin_o(margin_o)
    );

    // Expected {enable, data} for one lane, from the requirements.
    function automatic logic [1:0] exp_lane(int i);
        if (fault[i])                    return 2'b00;
        if (m_deact[i])                  return 2'b00;
        if (los[i] && !m_sqdis[i])       return 2'b00;
        return {1'b1, din[i] ^ m_inv[i]};
    endfunction

    function automatic string cause_tag(int i);
        if (fault[i])              return "R6";
        if (m_deact[i])            return "R3";
        if (los[i] && !m_sqdis[i]) return "R4";
        if (los[i])                return "R5";
        return "R2";
    endfunction

    task automatic check(string tag);
        bit bad = 0;
        vectors++;
        for (int i = 0; i < N; i++) begin
            logic [1:0] e = exp_lane(i);
            if ({lane_en[i], dout[i]} !== e) begin
                bad = 1;
                $display("FAIL %s/%s lane %0d en/dout actual %b%b expected %b",
                         tag, cause_tag(i), i, lane_en[i], dout[i], e);
            end
        end
        if (margin_o !== m_margin) begin
            bad = 1;
            $display("FAIL %s/R8 margin actual %h expected %h", tag, margin_o, m_margin);
        end
        if (bad) miscompares++;
    endtask

    task automatic step(logic [N-1:0] d, logic [N-1:0] l, logic [N-1:0] f,
                        logic we, logic [1:0] fld, logic [N-1:0] wd, logic cr, string tag);
        @(negedge clk);
        din = d; los = l; fault = f;
        cfg_wr = we; cfg_field = fld; cfg_wdata = wd; cfg_rst = cr;
        #1 check(tag);
        @(posedge clk);
        if (cr) begin
            m_inv = '0; m_deact = '0; m_sqdis = '0; m_margin = '0;
        end else if (we) begin
            case (fld)
                2'd0: m_inv = wd;
                2'd1: m_deact = wd;
                2'd2: m_sqdis = wd;
                default: m_margin = wd;
            endcase
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R11: defaults pass data unmodified
        step(12'hA5C, '0, '0, 0, 2'd0, '0, 0, "R11");
        step(12'h3F0, '0, '0, 0, 2'd0, '0, 0, "R11");
        // R10: write is not visible before its edge, visible after
        step(12'h0F0, '0, '0, 1, 2'd0, 12'hFFF, 0, "R10");
        step(12'h0F0, '0, '0, 0, 2'd0, '0, 0, "R10");
        // R7: all lanes quiet with inversion set still drive 0
        step(12'h000, 12'hFFF, '0, 0, 2'd0, '0, 0, "R7");
        step(12'h000, '0, 12'hFFF, 0, 2'd0, '0, 0, "R7");
        // R1: single lane deactivated, others untouched
        step(12'h555, '0, '0, 1, 2'd1, 12'h010, 0, "R1");
        step(12'h555, '0, '0, 0, 2'd0, '0, 0, "R1");
        // R5: squelch override on even lanes
        step(12'hFFF, 12'hFFF, '0, 1, 2'd2, 12'h555, 0, "R5");
        step(12'hFFF, 12'hFFF, '0, 0, 2'd0, '0, 0, "R5");
        // R6: fault overrides squelch-disable
        step(12'h000, 12'hFFF, 12'h00F, 1, 2'd3, 12'h9C3, 0, "R6");
        step(12'h000, 12'hFFF, 12'h00F, 0, 2'd0, '0, 0, "R8");
        // R9: control reset restores defaults
        step(12'h123, 12'h0F0, '0, 0, 2'd0, '0, 1, "R9");
        step(12'h123, 12'h0F0, '0, 0, 2'd0, '0, 0, "R9");
        // R2/R3/R4/R5/R6: random mix
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r = $urandom;
            step(N'($urandom), N'($urandom & $urandom), N'($urandom & $urandom & $urandom),
                 r[3:0] < 4'd5, r[5:4], N'($urandom), r[11:6] == 6'd0, "R2");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule